// File: doc/BRIEF.md
# SHA-256 Four-Round Half-State Update

This unit moves a SHA-256 compression state forward by four rounds. The eight-word working state is passed as two 128-bit halves. The primary operand `half_d` is the half that gets updated and returned. The secondary operand `half_n` is the other half. A third 128-bit input, `wk`, carries four words that already hold the message word plus the round constant. Word k of any 128-bit bus sits in bits [32k+31:32k].

A two-bit `mode` selects which half comes back:
- Mode 0 takes `half_d` = {D,C,B,A} (A in word 0) and `half_n` = {H,G,F,E}, and returns the new A..D half.
- Mode 1 takes `half_d` = {H,G,F,E} and `half_n` = {D,C,B,A}, and returns the new E..H half.

Running both modes on the same eight words gives the full state after four rounds. Mode 1 uses the secondary half only in its unmodified form.

The operation starts with a `start` pulse while the unit is idle. It then runs one round per clock and ends with a one-cycle `done` and a registered 128-bit `result`.

Top module: `sha256_quad_round`

## Requirements
- R1: After reset, `busy`, `done` and `illegal` are low and `result` is zero.
- R2: A `start` with mode 0 or 1 while idle raises `busy` on the next cycle. After four rounds, `busy` falls and `done` is high for exactly one cycle; this is the fourth clock after the clock that accepted the start.
- R3: Mode 0 returns {D',C',B',A'}, the first half after four standard rounds. Each round uses T1 = H + Σ1(E) + Ch(E,F,G) + wk[i] and T2 = Σ0(A) + Maj(A,B,C). Σ0 is the XOR of right rotations by 2, 13 and 22. Σ1 is the XOR of right rotations by 6, 11 and 25.
- R4: Mode 1 with `half_d`={H,G,F,E} and `half_n`={D,C,B,A} returns {H',G',F',E'} of the same four rounds. In round i, the new E is the unmodified `half_n` word 3−i plus T1.
- R5: All additions wrap modulo 2^32, and `wk` words are consumed in order 0, 1, 2, 3.
- R6: A `start` with mode 3 while idle pulses `illegal` for one cycle, leaves `busy` low and leaves `result` unchanged.
- R7: A `start` with mode 2 while idle is ignored: no `busy`, `illegal` or `done`, and `result` is unchanged.
- R8: A `start` while `busy` is ignored. The running operation completes with its own result and only one `done`.
- R9: `result` changes only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a four-round update (accepted when idle) |
| mode | input | 2 | 0 first half, 1 second half, 2 reserved, 3 illegal |
| half_d | input | 128 | Half that is updated and returned |
| half_n | input | 128 | Other half of the working state |
| wk | input | 128 | Four message-plus-constant words, word 0 used first |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an illegal mode code |
| result | output | 128 | Registered updated half |

## Verification
The assertions watch the handshake on every cycle:
- an accepted start leads to busy;
- every done pulse follows exactly four busy cycles and lasts one cycle;
- mode 3 gives an illegal pulse with no state change, and mode 2 gives nothing;
- the result never moves outside a done cycle.

The arithmetic itself is shown only by the bench scenarios. They compare both half-modes against an independent eight-word four-round model. The stimulus includes all-zero, all-one and mixed patterns, plus a start that collides with a running operation.

// File: rtl/sha256_quad_round.sv
module sha256_quad_round #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  localparam int HALF_W = WORD_W * LANES,
  localparam int CW     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [HALF_W-1:0] half_d,
  input  logic [HALF_W-1:0] half_n,
  input  logic [HALF_W-1:0] wk,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [HALF_W-1:0] result
);

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int s);
    return (x >> s) | (x << (WORD_W - s));
  endfunction

  function automatic word_t f_ch(input word_t x, input word_t y, input word_t z);
    return (x & (y ^ z)) ^ z;
  endfunction

  function automatic word_t f_maj(input word_t x, input word_t y, input word_t z);
    return (x & y) | ((x | y) & z);
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  logic [HALF_W-1:0] d_r, n_r, wk_r, d_nx, n_nx;
  logic              second_r;
  logic [CW-1:0]     cnt;
  word_t             dw [LANES];
  word_t             nw [LANES];
  word_t             w_cur, n_pick, t1, t2;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      dw[i] = d_r[i*WORD_W +: WORD_W];
      nw[i] = n_r[i*WORD_W +: WORD_W];
    end
    w_cur  = wk_r[int'(cnt)*WORD_W +: WORD_W];
    n_pick = n_r[(LANES-1-int'(cnt))*WORD_W +: WORD_W];
    t2     = '0;
    if (!second_r) begin
      t1   = f_ch(nw[0], nw[1], nw[2]) + nw[LANES-1] + big_s1(nw[0]) + w_cur;
      t2   = t1 + f_maj(dw[0], dw[1], dw[2]) + big_s0(dw[0]);
      d_nx = {d_r[HALF_W-WORD_W-1:0], t2};
      n_nx = {n_r[HALF_W-WORD_W-1:0], dw[LANES-1] + t1};
    end else begin
      t1   = f_ch(dw[0], dw[1], dw[2]) + dw[LANES-1] + big_s1(dw[0]) + w_cur;
      d_nx = {d_r[HALF_W-WORD_W-1:0], n_pick + t1};
      n_nx = n_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_r      <= '0;
      n_r      <= '0;
      wk_r     <= '0;
      second_r <= 1'b0;
      cnt      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (busy) begin
        d_r <= d_nx;
        n_r <= n_nx;
        cnt <= cnt + CW'(1);
        if (cnt == CW'(LANES-1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= d_nx;
        end
      end else if (start) begin
        case (mode)
          2'd0, 2'd1: begin
            d_r      <= half_d;
            n_r      <= half_n;
            wk_r     <= wk;
            second_r <= mode[0];
            cnt      <= '0;
            busy     <= 1'b1;
          end
          2'd3:    illegal <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sha256_quad_round_chk.sv
module sha256_quad_round_chk #(
  parameter int HALF_W = 128,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        mode,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [HALF_W-1:0] result
);

  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 8'd1 : 8'd0;
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !mode[1]) |=> busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_round_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run == 8'(LANES) && !busy));

  assert_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'd3) |=> (illegal && !busy && $stable(result)));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'd2) |=> (!illegal && !busy && !done));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !illegal);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind sha256_quad_round sha256_quad_round_chk #(.HALF_W(HALF_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .done(done), .illegal(illegal), .result(result)
);

// File: tb/tb_sha256_quad_round.sv
module tb_sha256_quad_round;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [127:0] half_d = '0, half_n = '0, wk = '0;
  logic         busy, done, illegal;
  logic [127:0] result;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sha256_quad_round dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .half_d(half_d),
    .half_n(half_n), .wk(wk), .busy(busy), .done(done), .illegal(illegal),
    .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int s);
    return {x, x} >> s;
  endfunction

  // independent eight-word reference: word 0 of each half is A / E
  task automatic ref4(input logic [127:0] abcd, input logic [127:0] efgh,
                      input logic [127:0] k, output logic [127:0] abcd_o,
                      output logic [127:0] efgh_o);
    logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
    {d, c, b, a} = abcd;
    {h, g, f, e} = efgh;
    for (int i = 0; i < 4; i++) begin
      x1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + k[i*32 +: 32];
      x2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + x1;
      d = c; c = b; b = a; a = x1 + x2;
    end
    abcd_o = {d, c, b, a};
    efgh_o = {h, g, f, e};
  endtask

  task automatic launch(input logic [1:0] m, input logic [127:0] x,
                        input logic [127:0] y, input logic [127:0] k);
    @(negedge clk);
    start = 1'b1; mode = m; half_d = x; half_n = y; wk = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] m, input logic [127:0] x,
                        input logic [127:0] y, input logic [127:0] k,
                        input logic [127:0] exp, input string req);
    int n;
    launch(m, x, y, k);
    chk(busy === 1'b1, "R2 busy after start", {127'd0, busy}, 128'd1);
    n = 0;
    while (done !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 4, "R2 latency", 128'(n), 128'd4);
    chk(busy === 1'b0, "R2 busy falls with done", {127'd0, busy}, 128'd0);
    chk(result === exp, req, result, exp);
    @(negedge clk);
    chk(done === 1'b0, "R2 done single cycle", {127'd0, done}, 128'd0);
  endtask

  task automatic test_pair(input logic [127:0] abcd, input logic [127:0] efgh,
                           input logic [127:0] k);
    logic [127:0] ea, ee;
    ref4(abcd, efgh, k, ea, ee);
    run_op(2'd0, abcd, efgh, k, ea, "R3 first half");
    run_op(2'd1, efgh, abcd, k, ee, "R4 second half");
  endtask

  task automatic test_reset;
    chk(busy === 1'b0 && done === 1'b0 && illegal === 1'b0,
        "R1 reset flags", {125'd0, busy, done, illegal}, 128'd0);
    chk(result === '0, "R1 reset result", result, 128'd0);
  endtask

  task automatic test_illegal;
    logic [127:0] prev = result;
    launch(2'd3, ~prev, 128'h5, 128'h9);
    chk(illegal === 1'b1 && busy === 1'b0, "R6 illegal pulse, no busy",
        {126'd0, illegal, busy}, 128'd2);
    chk(result === prev, "R6 result kept", result, prev);
    @(negedge clk);
    chk(illegal === 1'b0, "R6 illegal one cycle", {127'd0, illegal}, 128'd0);
  endtask

  task automatic test_reserved;
    logic [127:0] prev = result;
    bit seen = 1'b0;
    launch(2'd2, ~prev, 128'h7, 128'h3);
    for (int i = 0; i < 6; i++) begin
      if (busy || illegal || done) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R7 mode 2 no activity", {127'd0, seen}, 128'd0);
    chk(result === prev, "R7 result kept", result, prev);
  endtask

  task automatic test_collision;
    logic [127:0] abcd = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    logic [127:0] efgh = 128'h13579bdf_2468ace0_fdb97531_0eca8642;
    logic [127:0] k    = 128'h11223344_55667788_99aabbcc_ddeeff00;
    logic [127:0] ea, ee;
    int dones = 0;
    bit ill = 1'b0;
    ref4(abcd, efgh, k, ea, ee);
    launch(2'd0, abcd, efgh, k);
    start = 1'b1; mode = 2'd3; half_d = '1; half_n = '1; wk = '1;
    @(negedge clk);
    if (illegal) ill = 1'b1;
    mode = 2'd1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (done) begin
        dones++;
        chk(result === ea, "R8 running result unaffected", result, ea);
      end
      if (illegal) ill = 1'b1;
      @(negedge clk);
    end
    chk(dones == 1, "R8 single done", 128'(dones), 128'd1);
    chk(!ill, "R8 no illegal while busy", {127'd0, ill}, 128'd0);
    chk(result === ea, "R9 result held after done", result, ea);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    // standard initial state with arbitrary schedule words
    test_pair(128'ha54ff53a_3c6ef372_bb67ae85_6a09e667,
              128'h5be0cd19_1f83d9ab_9b05688c_510e527f,
              128'he9b5dba5_b5c0fbcf_71374491_c2e3ec4a);
    // R5 zeros and all-ones (every add carries out and wraps)
    test_pair('0, '0, '0);
    test_pair('1, '1, '1);
    // R5 single word of wk set, distinguishes word order
    test_pair(128'h1, 128'h2, 128'h80000000_00000000_00000000_00000000);
    test_pair(128'h1, 128'h2, 128'h00000000_00000000_00000000_80000000);
    for (int p = 0; p < 3; p++) begin
      logic [127:0] x, y, z;
      for (int j = 0; j < 4; j++) begin
        x[j*32 +: 32] = 32'h9e3779b9 * (p*4 + j + 1);
        y[j*32 +: 32] = 32'h85ebca6b * (p*4 + j + 7) ^ 32'hdeadbeef;
        z[j*32 +: 32] = 32'hc2b2ae35 * (p + j + 3);
      end
      test_pair(x, y, z);
    end
    test_illegal;
    test_reserved;
    test_collision;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule